// File: doc/BRIEF.md
# Two-Level Instruction Control Decoder

This block turns the opcode and function fields of a 32-bit instruction into the control lines of a single-cycle datapath. The instruction subset has seven members: register add and subtract (plus register and, or and set-less-than through the function field), or-with-immediate, load word, store word, branch-if-equal and jump. The block is purely combinational and has no state.

Decoding is split into two levels. A main decoder looks only at the 6-bit opcode. It drives the register-destination select, the ALU operand select, the memory-to-register select, the two write enables, the branch and jump requests, the extender mode and a 3-bit intermediate ALU operation code. A local ALU decoder then combines that code with the function field to produce the 3-bit ALU control. Every output that the instruction does not use is driven to 0. An opcode or function value outside the subset raises an illegal flag and holds all write enables and flow requests low.

Top module: `insn_ctl_dec`

## Requirements
- R1: Opcode 000000 (register type) with a legal function gives reg_dst=1, alu_op=100, reg_write=1, illegal=0, and 0 on alu_src, mem_to_reg, mem_write, branch, jump and ext_op.
- R2: Opcode 001101 (or immediate) gives alu_src=1, reg_write=1, ext_op=0, alu_op=010, alu_ctl=110 and 0 on every other output.
- R3: Opcode 100011 (load) gives alu_src=1, mem_to_reg=1, reg_write=1, ext_op=1, alu_op=000, alu_ctl=000 and 0 on every other output.
- R4: Opcode 101011 (store) gives alu_src=1, mem_write=1, ext_op=1, alu_op=000, alu_ctl=000 and 0 on every other output, reg_write included.
- R5: Opcode 000100 (branch if equal) gives branch=1, alu_src=0, alu_op=001, alu_ctl=001 and 0 on every other output.
- R6: Opcode 000010 (jump) gives jump=1 and 0 on every other output; alu_ctl is 000.
- R7: With alu_op=100, alu_ctl follows funct[3:0]: 0000 gives 000 (add), 0010 gives 001 (subtract), 0100 gives 010 (and), 0101 gives 110 (or), 1010 gives 111 (set-less-than); funct[5:4] has no effect.
- R8: For every opcode other than 000000, the funct field has no effect on any output.
- R9: Any opcode outside the six above drives every control output and alu_op and alu_ctl to 0 and sets illegal=1.
- R10: Opcode 000000 with funct[3:0] outside the five legal values gives illegal=1, reg_write=0, alu_ctl=000, while reg_dst=1 and alu_op=100 remain.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| opcode | input | 6 | Instruction opcode field |
| funct | input | 6 | Instruction function field |
| reg_dst | output | 1 | 1 selects the rd field as write destination, 0 the rt field |
| alu_src | output | 1 | 1 selects the extended immediate as second ALU operand |
| mem_to_reg | output | 1 | 1 selects data memory output as write-back data |
| reg_write | output | 1 | Register file write enable |
| mem_write | output | 1 | Data memory write enable |
| branch | output | 1 | Conditional branch request |
| jump | output | 1 | Jump request |
| ext_op | output | 1 | 1 sign-extends the immediate, 0 zero-extends it |
| alu_op | output | 3 | Intermediate ALU operation code from the main decoder |
| alu_ctl | output | 3 | Final ALU operation control |
| illegal | output | 1 | Opcode or function outside the supported subset |

## Verification
The two functions that meet in one evaluation are the local function decode and the illegal-instruction guard: a register-type opcode carrying an unlisted function value must keep the main decoder's destination and operation code while the guard drops the register write and forces the ALU control to add. This is provoked by an exhaustive sweep over all opcode and function pairs, followed by seeded random pairs biased towards the legal opcodes, and each pair is judged against a bench reference function built from the requirements, comparing every output bit at once.

// File: rtl/ctl_pkg.sv
package ctl_pkg;

  localparam int OP_W  = 6;
  localparam int FN_W  = 6;
  localparam int AOP_W = 3;
  localparam int CTL_W = 3;

  localparam logic [OP_W-1:0] OPC_RTYPE = 6'b000000;
  localparam logic [OP_W-1:0] OPC_ORI   = 6'b001101;
  localparam logic [OP_W-1:0] OPC_LOAD  = 6'b100011;
  localparam logic [OP_W-1:0] OPC_STORE = 6'b101011;
  localparam logic [OP_W-1:0] OPC_BEQ   = 6'b000100;
  localparam logic [OP_W-1:0] OPC_JUMP  = 6'b000010;

  localparam logic [AOP_W-1:0] AOP_ADD   = 3'b000;
  localparam logic [AOP_W-1:0] AOP_SUB   = 3'b001;
  localparam logic [AOP_W-1:0] AOP_OR    = 3'b010;
  localparam logic [AOP_W-1:0] AOP_RTYPE = 3'b100;

  localparam logic [CTL_W-1:0] CTL_ADD = 3'b000;
  localparam logic [CTL_W-1:0] CTL_SUB = 3'b001;
  localparam logic [CTL_W-1:0] CTL_AND = 3'b010;
  localparam logic [CTL_W-1:0] CTL_OR  = 3'b110;
  localparam logic [CTL_W-1:0] CTL_SLT = 3'b111;

  typedef struct packed {
    logic             reg_dst;
    logic             alu_src;
    logic             mem_to_reg;
    logic             reg_write;
    logic             mem_write;
    logic             branch;
    logic             jump;
    logic             ext_op;
    logic [AOP_W-1:0] alu_op;
  } main_ctl_t;

endpackage

// File: rtl/ctl_main_dec.sv
module ctl_main_dec
  import ctl_pkg::*;
(
  input  logic [OP_W-1:0] opcode,
  output main_ctl_t       ctl,
  output logic            op_bad
);

  always_comb begin
    ctl    = '0;
    op_bad = 1'b0;
    unique case (opcode)
      OPC_RTYPE: begin
        ctl.reg_dst   = 1'b1;
        ctl.reg_write = 1'b1;
        ctl.alu_op    = AOP_RTYPE;
      end
      OPC_ORI: begin
        ctl.alu_src   = 1'b1;
        ctl.reg_write = 1'b1;
        ctl.alu_op    = AOP_OR;
      end
      OPC_LOAD: begin
        ctl.alu_src    = 1'b1;
        ctl.mem_to_reg = 1'b1;
        ctl.reg_write  = 1'b1;
        ctl.ext_op     = 1'b1;
        ctl.alu_op     = AOP_ADD;
      end
      OPC_STORE: begin
        ctl.alu_src   = 1'b1;
        ctl.mem_write = 1'b1;
        ctl.ext_op    = 1'b1;
        ctl.alu_op    = AOP_ADD;
      end
      OPC_BEQ: begin
        ctl.branch = 1'b1;
        ctl.alu_op = AOP_SUB;
      end
      OPC_JUMP: begin
        ctl.jump = 1'b1;
      end
      default: begin
        op_bad = 1'b1;
      end
    endcase
  end

endmodule

// File: rtl/ctl_alu_dec.sv
module ctl_alu_dec
  import ctl_pkg::*;
(
  input  logic [AOP_W-1:0] alu_op,
  input  logic [FN_W-1:0]  funct,
  output logic [CTL_W-1:0] alu_ctl,
  output logic             fn_bad
);

  logic [CTL_W-1:0] fn_ctl;
  logic             fn_miss;
  logic [CTL_W-1:0] op_ctl;

  // function-field path; the two upper bits are wildcards
  always_comb begin
    fn_ctl  = CTL_ADD;
    fn_miss = 1'b0;
    casez (funct)
      6'b??0000: fn_ctl = CTL_ADD;
      6'b??0010: fn_ctl = CTL_SUB;
      6'b??0100: fn_ctl = CTL_AND;
      6'b??0101: fn_ctl = CTL_OR;
      6'b??1010: fn_ctl = CTL_SLT;
      default:   fn_miss = 1'b1;
    endcase
  end

  // direct path for codes that name the operation themselves
  always_comb begin
    case (alu_op[1:0])
      2'b01:   op_ctl = CTL_SUB;
      2'b10:   op_ctl = CTL_OR;
      default: op_ctl = CTL_ADD;
    endcase
  end

  assign fn_bad  = alu_op[AOP_W-1] & fn_miss;
  assign alu_ctl = alu_op[AOP_W-1] ? fn_ctl : op_ctl;

endmodule

// File: rtl/insn_ctl_dec.sv
module insn_ctl_dec
  import ctl_pkg::*;
(
  input  logic [OP_W-1:0]  opcode,
  input  logic [FN_W-1:0]  funct,
  output logic             reg_dst,
  output logic             alu_src,
  output logic             mem_to_reg,
  output logic             reg_write,
  output logic             mem_write,
  output logic             branch,
  output logic             jump,
  output logic             ext_op,
  output logic [AOP_W-1:0] alu_op,
  output logic [CTL_W-1:0] alu_ctl,
  output logic             illegal
);

  main_ctl_t        mctl;
  logic             op_bad;
  logic             fn_bad;
  logic [CTL_W-1:0] raw_ctl;

  ctl_main_dec i_main (
    .opcode (opcode),
    .ctl    (mctl),
    .op_bad (op_bad)
  );

  ctl_alu_dec i_alu (
    .alu_op  (mctl.alu_op),
    .funct   (funct),
    .alu_ctl (raw_ctl),
    .fn_bad  (fn_bad)
  );

  // guard: an unknown function code silences the write and the ALU choice
  assign illegal    = op_bad | fn_bad;
  assign reg_dst    = mctl.reg_dst;
  assign alu_src    = mctl.alu_src;
  assign mem_to_reg = mctl.mem_to_reg;
  assign reg_write  = mctl.reg_write & ~fn_bad;
  assign mem_write  = mctl.mem_write;
  assign branch     = mctl.branch;
  assign jump       = mctl.jump;
  assign ext_op     = mctl.ext_op;
  assign alu_op     = mctl.alu_op;
  assign alu_ctl    = fn_bad ? CTL_ADD : raw_ctl;

endmodule

// File: rtl/ctl_dec_chk.sv
module ctl_dec_chk
  import ctl_pkg::*;
(
  input logic [OP_W-1:0]  opcode,
  input logic [FN_W-1:0]  funct,
  input logic             reg_dst,
  input logic             alu_src,
  input logic             mem_to_reg,
  input logic             reg_write,
  input logic             mem_write,
  input logic             branch,
  input logic             jump,
  input logic             ext_op,
  input logic [AOP_W-1:0] alu_op,
  input logic [CTL_W-1:0] alu_ctl,
  input logic             illegal
);

  always_comb begin
    p_one_action_r6: assert ($onehot0({reg_write, mem_write, branch, jump}));
    if (illegal)
      p_illegal_quiet_r9: assert (!reg_write && !mem_write && !branch && !jump);
    if (mem_to_reg)
      p_load_path_r3: assert (reg_write && alu_src && ext_op && opcode == OPC_LOAD);
    if (branch)
      p_branch_sub_r5: assert (alu_ctl == CTL_SUB && !alu_src);
    if (opcode == OPC_ORI)
      p_ori_ctl_r2: assert (alu_ctl == CTL_OR && !ext_op);
    if (alu_op == AOP_RTYPE && !illegal)
      p_rtype_ctl_r7: assert (alu_ctl != 3'b011 && alu_ctl[2:1] != 2'b10 && reg_dst);
    if (opcode == OPC_RTYPE && illegal)
      p_bad_funct_r10: assert (!reg_write && alu_ctl == CTL_ADD && funct[3:0] != 4'b0000);
    if (mem_write)
      p_store_r4: assert (!reg_write && alu_src && ext_op);
  end

endmodule

bind insn_ctl_dec ctl_dec_chk i_chk (
  .opcode     (opcode),
  .funct      (funct),
  .reg_dst    (reg_dst),
  .alu_src    (alu_src),
  .mem_to_reg (mem_to_reg),
  .reg_write  (reg_write),
  .mem_write  (mem_write),
  .branch     (branch),
  .jump       (jump),
  .ext_op     (ext_op),
  .alu_op     (alu_op),
  .alu_ctl    (alu_ctl),
  .illegal    (illegal)
);

// File: tb/test_insn_ctl_dec.sv
`timescale 1ns/1ps
module test_insn_ctl_dec;

  logic       clk;
  logic       rst_n;
  logic [5:0] opcode;
  logic [5:0] funct;
  logic       reg_dst, alu_src, mem_to_reg, reg_write, mem_write;
  logic       branch, jump, ext_op, illegal;
  logic [2:0] alu_op, alu_ctl;

  int total = 0;
  int bad   = 0;

  insn_ctl_dec i_insn_ctl_dec (
    .opcode     (opcode),
    .funct      (funct),
    .reg_dst    (reg_dst),
    .alu_src    (alu_src),
    .mem_to_reg (mem_to_reg),
    .reg_write  (reg_write),
    .mem_write  (mem_write),
    .branch     (branch),
    .jump       (jump),
    .ext_op     (ext_op),
    .alu_op     (alu_op),
    .alu_ctl    (alu_ctl),
    .illegal    (illegal)
  );

  initial clk = 1'b0;
  always #2.5 clk = ~clk;

  // packed order: reg_dst alu_src mem_to_reg reg_write mem_write branch jump ext_op alu_op alu_ctl illegal
  function automatic logic [14:0] ref_out(input logic [5:0] op, input logic [5:0] fn);
    logic [2:0] c;
    logic       ok;
    ok = 1'b1;
    case (fn[3:0])
      4'b0000: c = 3'b000;
      4'b0010: c = 3'b001;
      4'b0100: c = 3'b010;
      4'b0101: c = 3'b110;
      4'b1010: c = 3'b111;
      default: begin c = 3'b000; ok = 1'b0; end
    endcase
    case (op)
      6'b000000: ref_out = {1'b1, 1'b0, 1'b0, ok, 1'b0, 1'b0, 1'b0, 1'b0, 3'b100, c, ~ok};
      6'b001101: ref_out = {8'b01010000, 3'b010, 3'b110, 1'b0};
      6'b100011: ref_out = {8'b01110001, 3'b000, 3'b000, 1'b0};
      6'b101011: ref_out = {8'b01001001, 3'b000, 3'b000, 1'b0};
      6'b000100: ref_out = {8'b00000100, 3'b001, 3'b001, 1'b0};
      6'b000010: ref_out = {8'b00000010, 3'b000, 3'b000, 1'b0};
      default:   ref_out = {8'b00000000, 3'b000, 3'b000, 1'b1};
    endcase
  endfunction

  function automatic string tag_of(input logic [5:0] op, input logic [5:0] fn);
    case (op)
      6'b000000: begin
        case (fn[3:0])
          4'b0000, 4'b0010, 4'b0100, 4'b0101, 4'b1010: tag_of = "R1/R7";
          default: tag_of = "R10";
        endcase
      end
      6'b001101: tag_of = "R2/R8";
      6'b100011: tag_of = "R3/R8";
      6'b101011: tag_of = "R4/R8";
      6'b000100: tag_of = "R5/R8";
      6'b000010: tag_of = "R6/R8";
      default:   tag_of = "R9";
    endcase
  endfunction

  task automatic apply(input logic [5:0] op, input logic [5:0] fn, input string tag);
    logic [14:0] got;
    logic [14:0] exp;
    @(negedge clk);
    opcode = op;
    funct  = fn;
    @(posedge clk);
    #1;
    got = {reg_dst, alu_src, mem_to_reg, reg_write, mem_write, branch, jump,
           ext_op, alu_op, alu_ctl, illegal};
    exp = ref_out(op, fn);
    total++;
    if (got !== exp) begin
      bad++;
      $display("FAIL %s op=%b fn=%b actual=%b expected=%b", tag, op, fn, got, exp);
    end
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    bad++;
    $display("FAIL watchdog expired");
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    int unsigned seed;
    logic [5:0]  op;
    logic [5:0]  fn;
    seed   = 32'd1234;
    opcode = 6'b000000;
    funct  = 6'b100000;
    rst_n  = 1'b0;
    repeat (3) @(posedge clk);
    rst_n  = 1'b1;

    // idle state after reset: register add
    apply(6'b000000, 6'b100000, "R1 idle");
    // directed R7 function map, upper bits varied (ignored)
    apply(6'b000000, 6'b100000, "R7 add");
    apply(6'b000000, 6'b010010, "R7 sub");
    apply(6'b000000, 6'b000100, "R7 and");
    apply(6'b000000, 6'b110101, "R7 or");
    apply(6'b000000, 6'b101010, "R7 slt");
    apply(6'b000000, 6'b100001, "R10 bad funct");
    apply(6'b000000, 6'b111111, "R10 bad funct");
    apply(6'b001101, 6'b111111, "R2");
    apply(6'b100011, 6'b101010, "R3");
    apply(6'b101011, 6'b000000, "R4");
    apply(6'b000100, 6'b100101, "R5");
    apply(6'b000010, 6'b100010, "R6");
    apply(6'b111111, 6'b100000, "R9");
    apply(6'b000001, 6'b000000, "R9");

    // exhaustive sweep: every opcode with every function value
    for (int o = 0; o < 64; o++) begin
      for (int f = 0; f < 64; f++) begin
        op = 6'(o);
        fn = 6'(f);
        apply(op, fn, tag_of(op, fn));
      end
    end

    // seeded random, biased to the legal opcodes
    void'($urandom(seed));
    for (int i = 0; i < 1500; i++) begin
      case ($urandom_range(7, 0))
        0:       op = 6'b000000;
        1:       op = 6'b001101;
        2:       op = 6'b100011;
        3:       op = 6'b101011;
        4:       op = 6'b000100;
        5:       op = 6'b000010;
        6:       op = 6'b000000;
        default: op = 6'($urandom_range(63, 0));
      endcase
      fn = 6'($urandom_range(63, 0));
      apply(op, fn, tag_of(op, fn));
    end

    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

endmodule